// File: doc/BRIEF.md
# SD host interrupt status unit

This block keeps the interrupt status of an SD card host controller. It takes single-cycle event pulses from the command path, the data path and the DMA logic. It then latches normal and error status bits, each one gated by a status-enable bit. It drives a single registered interrupt request from the status bits that software has chosen to signal. A small register port lets software read the status and enable words, and clear status bits by writing 1.

The block also watches command responses. A command-issue pulse starts a count of SD clock ticks. The matching response either reports completion or, if it does not arrive within the timeout window, flags a command timeout. The two outcomes exclude each other for one command. In the same way, a data timeout inside an open transfer cancels that transfer's completion report. On the first DMA descriptor fault, a companion register captures the DMA engine's state.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset, every readable word (addresses 0 to 6) reads 0 and irq_o is 0.
- R2: A response pulse while a command is outstanding sets normal status bit 0 (command done) at that clock edge, with command timeout (error bit 0) left clear.
- R3: With no response, the RSP_TIMEOUT-th SD tick (sd_tick_i high at an edge) after the issue pulse sets error bit 0 at that edge, and no earlier tick does. Command done stays clear, and a response arriving later is ignored.
- R4: A response on the same edge as the final tick wins: command done sets and timeout stays clear. Once a command is resolved, further ticks cause no timeout until the next issue pulse.
- R5: A transfer-end pulse after a transfer-start pulse, with no data timeout in between, sets normal bit 1 (transfer done).
- R6: A data-timeout pulse inside an open transfer sets error bit 4 and closes the transfer, so its end pulse sets no transfer done. This includes a timeout on the same edge as the end pulse. A data-timeout pulse with no transfer open has no effect.
- R7: A DMA-error pulse sets error bit 12, and a descriptor-fault pulse sets error bit 9.
- R8: A status bit latches only while its bit in the matching status-enable word is 1. Address 2 holds the normal status enables and address 3 the error status enables.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Address 0 holds the normal status and address 1 the error status. Unimplemented bits always read 0; the implemented bits are 0x0003 for the normal word and 0x1211 for the error word. Enable words keep only the implemented bits.
- R10: If an event sets a bit on the same edge as a write-1 clear of that bit, the bit ends up set.
- R11: irq_o is registered. It rises one edge after a status bit and its signal-enable bit (normal at address 4, error at address 5) are first both 1. It falls one edge after the last such pair stops being 1.
- R12: Address 6 captures adma_state_i only on an edge where error bit 9 goes from 0 to 1. A fault that arrives while bit 9 is already set leaves the captured value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sd_tick_i | input | 1 | One pulse per SD card clock cycle |
| cmd_issue_i | input | 1 | Command sent to the card |
| rsp_rcvd_i | input | 1 | Command response received |
| xfer_start_i | input | 1 | Data transfer opened |
| xfer_end_i | input | 1 | Data transfer finished |
| data_to_i | input | 1 | Data timeout detected |
| dma_err_i | input | 1 | DMA transaction error |
| adma_err_i | input | 1 | Descriptor DMA error or invalid descriptor |
| adma_state_i | input | ADMA_ST_W | Descriptor engine state, captured on fault |
| we_i | input | 1 | Register write strobe |
| waddr_i | input | 3 | Register write address |
| wdata_i | input | 16 | Register write data |
| raddr_i | input | 3 | Register read address |
| rdata_o | output | 16 | Read data for raddr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 64-tick response timeout and a 2-bit descriptor state. With these values it can step to the exact 63rd and 64th tick after an issue pulse. It can also make the response and the final tick meet on one edge. The 2-bit state lets it capture several distinct values and show that a second fault does not overwrite the first. It lines up same-edge collisions that only the event ordering decides: set against clear, data timeout against transfer end, and response against timeout.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_NSTAT = 3'd0,
    A_ESTAT = 3'd1,
    A_NSEN  = 3'd2,
    A_ESEN  = 3'd3,
    A_NSIG  = 3'd4,
    A_ESIG  = 3'd5,
    A_ACAP  = 3'd6
  } reg_addr_e;

  localparam int unsigned N_CMD_DONE  = 0;
  localparam int unsigned N_XFER_DONE = 1;
  localparam int unsigned E_CMD_TO    = 0;
  localparam int unsigned E_DATA_TO   = 4;
  localparam int unsigned E_ADMA      = 9;
  localparam int unsigned E_DMA       = 12;

  localparam logic [REG_W-1:0] N_MASK = REG_W'((1 << N_CMD_DONE) | (1 << N_XFER_DONE));
  localparam logic [REG_W-1:0] E_MASK = REG_W'((1 << E_CMD_TO) | (1 << E_DATA_TO) |
                                               (1 << E_ADMA) | (1 << E_DMA));
endpackage

// File: rtl/sdh_rsp_timer.sv
module sdh_rsp_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic issue_i,
  input  logic rsp_i,
  output logic done_o,
  output logic timeout_o
);
  localparam int unsigned CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          pending_q;
  logic [CW-1:0] cnt_q;

  // response on the final tick still counts as in time
  assign done_o    = pending_q & rsp_i & ~issue_i;
  assign timeout_o = pending_q & tick_i & ~rsp_i & ~issue_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else if (issue_i) begin
      pending_q <= 1'b1;
      cnt_q     <= '0;
    end else if (done_o || timeout_o) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else if (pending_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3
  rsp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
  // R4
  no_retimeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
endmodule

// File: rtl/sdh_xfer_track.sv
module sdh_xfer_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  input  logic dto_i,
  output logic done_o,
  output logic dto_o
);
  logic active_q;

  // timeout beats end on the same edge
  assign done_o = active_q & end_i & ~dto_i;
  assign dto_o  = active_q & dto_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               active_q <= 1'b0;
    else if (start_i)          active_q <= 1'b1;
    else if (end_i || dto_i)   active_q <= 1'b0;
  end

  // R6
  xfer_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && dto_o));
endmodule

// File: rtl/sdh_w1c_stat.sv
module sdh_w1c_stat #(
  parameter int unsigned  W    = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= ((stat_q & ~clr_i) | set_i) & MASK;
  end

  assign stat_o = stat_q;

  // R9
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~MASK) == '0);
  // R10
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & MASK)) |=> ((stat_q & $past(set_i & MASK)) == $past(set_i & MASK)));
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
#(
  parameter int unsigned RSP_TIMEOUT = 64,
  parameter int unsigned ADMA_ST_W   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sd_tick_i,
  input  logic                 cmd_issue_i,
  input  logic                 rsp_rcvd_i,
  input  logic                 xfer_start_i,
  input  logic                 xfer_end_i,
  input  logic                 data_to_i,
  input  logic                 dma_err_i,
  input  logic                 adma_err_i,
  input  logic [ADMA_ST_W-1:0] adma_state_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    waddr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [ADDR_W-1:0]    raddr_i,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 irq_o
);
  logic cmd_done, cmd_to, xfer_done, xfer_dto;
  logic [REG_W-1:0] nsen_q, esen_q, nsig_q, esig_q;
  logic [REG_W-1:0] nraw, eraw, nset, eset, nclr, eclr, nstat, estat;
  logic [ADMA_ST_W-1:0] acap_q;
  logic irq_q, irq_src;

  sdh_rsp_timer #(.LIMIT(RSP_TIMEOUT)) u_timer (
    .clk_i, .rst_ni, .tick_i(sd_tick_i), .issue_i(cmd_issue_i), .rsp_i(rsp_rcvd_i),
    .done_o(cmd_done), .timeout_o(cmd_to)
  );

  sdh_xfer_track u_xfer (
    .clk_i, .rst_ni, .start_i(xfer_start_i), .end_i(xfer_end_i), .dto_i(data_to_i),
    .done_o(xfer_done), .dto_o(xfer_dto)
  );

  always_comb begin
    nraw = '0;
    nraw[N_CMD_DONE]  = cmd_done;
    nraw[N_XFER_DONE] = xfer_done;
    eraw = '0;
    eraw[E_CMD_TO]  = cmd_to;
    eraw[E_DATA_TO] = xfer_dto;
    eraw[E_ADMA]    = adma_err_i;
    eraw[E_DMA]     = dma_err_i;
  end

  assign nset = nraw & nsen_q;
  assign eset = eraw & esen_q;
  assign nclr = (we_i && waddr_i == A_NSTAT) ? wdata_i : '0;
  assign eclr = (we_i && waddr_i == A_ESTAT) ? wdata_i : '0;

  sdh_w1c_stat #(.W(REG_W), .MASK(N_MASK)) u_nstat (
    .clk_i, .rst_ni, .set_i(nset), .clr_i(nclr), .stat_o(nstat)
  );
  sdh_w1c_stat #(.W(REG_W), .MASK(E_MASK)) u_estat (
    .clk_i, .rst_ni, .set_i(eset), .clr_i(eclr), .stat_o(estat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nsen_q <= '0;
      esen_q <= '0;
      nsig_q <= '0;
      esig_q <= '0;
    end else if (we_i) begin
      case (waddr_i)
        A_NSEN:  nsen_q <= wdata_i & N_MASK;
        A_ESEN:  esen_q <= wdata_i & E_MASK;
        A_NSIG:  nsig_q <= wdata_i & N_MASK;
        A_ESIG:  esig_q <= wdata_i & E_MASK;
        default: ;
      endcase
    end
  end

  // capture only on the 0->1 edge of the descriptor fault bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        acap_q <= '0;
    else if (eset[E_ADMA] && !estat[E_ADMA]) acap_q <= adma_state_i;
  end

  assign irq_src = |(nstat & nsig_q) | |(estat & esig_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_src;
  end
  assign irq_o = irq_q;

  always_comb begin
    case (raddr_i)
      A_NSTAT: rdata_o = nstat;
      A_ESTAT: rdata_o = estat;
      A_NSEN:  rdata_o = nsen_q;
      A_ESEN:  rdata_o = esen_q;
      A_NSIG:  rdata_o = nsig_q;
      A_ESIG:  rdata_o = esig_q;
      A_ACAP:  rdata_o = REG_W'(acap_q);
      default: rdata_o = '0;
    endcase
  end

  // R11
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(irq_src == 1'b0));
  // R12
  acap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(estat[E_ADMA]) |-> $stable(acap_q));
endmodule

// File: tb/tb_sdh_irq_status.sv
module tb_sdh_irq_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  localparam logic [7:0] TICK = 8'h01, ISS = 8'h02, RSP = 8'h04, XS = 8'h08,
                         XE = 8'h10, DTO = 8'h20, DMA = 8'h40, ADMA = 8'h80;
  localparam logic [2:0] IRQ_ADDR = 3'd7;

  logic [7:0]  ev = '0;
  logic [1:0]  astate = '0;
  logic        we = 1'b0;
  logic [2:0]  waddr = '0, raddr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        irq;

  sdh_irq_status dut (
    .clk_i(clk), .rst_ni(rst_n), .sd_tick_i(ev[0]), .cmd_issue_i(ev[1]),
    .rsp_rcvd_i(ev[2]), .xfer_start_i(ev[3]), .xfer_end_i(ev[4]), .data_to_i(ev[5]),
    .dma_err_i(ev[6]), .adma_err_i(ev[7]), .adma_state_i(astate), .we_i(we),
    .waddr_i(waddr), .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct {
    logic [2:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0;
  bit  done = 1'b0;

  // monitor: pops expected items and compares against the port
  initial begin
    forever begin
      wait (q.size() != 0);
      raddr = q[0].addr;
      #1;
      begin
        logic [15:0] act;
        act = (q[0].addr == IRQ_ADDR) ? {15'd0, irq} : rdata;
        checks++;
        if (act !== q[0].exp) begin
          failures++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", q[0].tag, q[0].addr, act, q[0].exp);
        end
      end
      void'(q.pop_front());
    end
  end

  task automatic expect_val(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic pulse(input logic [7:0] m);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic ticks(input int n);
    ev = TICK;
    repeat (n) @(negedge clk);
    ev = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pulse(input logic [2:0] a, input logic [15:0] d, input logic [7:0] m);
    we = 1'b1; waddr = a; wdata = d; ev = m;
    @(negedge clk);
    we = 1'b0; ev = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_pulse(a, d, 8'h00);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 7; a++) expect_val(3'(a), 16'h0000, "R1");
    expect_val(IRQ_ADDR, 16'h0000, "R1 irq");

    wr(3'd3, 16'hFFFF);
    wr(3'd2, 16'hFFFF);
    expect_val(3'd3, 16'h1211, "R9 esen mask");
    expect_val(3'd2, 16'h0003, "R9 nsen mask");

    // R2 response in time
    pulse(ISS); ticks(10); pulse(RSP);
    expect_val(3'd0, 16'h0001, "R2 cmd done");
    expect_val(3'd1, 16'h0000, "R2 no timeout");
    wr(3'd0, 16'h0001);
    expect_val(3'd0, 16'h0000, "R9 w1c clear");

    // R3 timeout at the 64th tick
    pulse(ISS); ticks(63);
    expect_val(3'd1, 16'h0000, "R3 tick63");
    ticks(1);
    expect_val(3'd1, 16'h0001, "R3 tick64");
    expect_val(3'd0, 16'h0000, "R3 no done");
    pulse(RSP);
    expect_val(3'd0, 16'h0000, "R3 late rsp");

    // R4 idle after resolution, response beats final tick
    ticks(100); wr(3'd1, 16'h0001); ticks(70);
    expect_val(3'd1, 16'h0000, "R4 idle");
    pulse(ISS); ticks(63); pulse(TICK | RSP);
    expect_val(3'd0, 16'h0001, "R4 rsp wins");
    expect_val(3'd1, 16'h0000, "R4 no timeout");
    ticks(5);
    expect_val(3'd1, 16'h0000, "R4 after");
    wr(3'd0, 16'h0001);

    // R5 transfer done
    pulse(XS); pulse(XE);
    expect_val(3'd0, 16'h0002, "R5 xfer done");
    wr(3'd0, 16'h0002);

    // R6 data timeout
    pulse(XS); pulse(DTO); pulse(XE);
    expect_val(3'd1, 16'h0010, "R6 dto");
    expect_val(3'd0, 16'h0000, "R6 no xfer done");
    wr(3'd1, 16'h0010);
    pulse(DTO);
    expect_val(3'd1, 16'h0000, "R6 dto outside");
    pulse(XS); pulse(DTO | XE);
    expect_val(3'd1, 16'h0010, "R6 same edge dto");
    expect_val(3'd0, 16'h0000, "R6 same edge no done");
    wr(3'd1, 16'h0010);

    // R7 / R12 DMA and descriptor faults
    astate = 2'd2;
    pulse(DMA);
    expect_val(3'd1, 16'h1000, "R7 dma");
    pulse(ADMA);
    expect_val(3'd1, 16'h1200, "R7 adma");
    expect_val(3'd6, 16'h0002, "R12 capture");
    astate = 2'd1;
    pulse(ADMA);
    expect_val(3'd6, 16'h0002, "R12 hold");
    wr(3'd1, 16'h1200);
    expect_val(3'd1, 16'h0000, "R9 clear both");
    pulse(ADMA);
    expect_val(3'd6, 16'h0001, "R12 recapture");
    wr(3'd1, 16'h0200);

    // R9 reserved bits
    wr(3'd1, 16'hFFFF);
    expect_val(3'd1, 16'h0000, "R9 reserved");

    // R8 status enable gates latching
    wr(3'd3, 16'h0000);
    pulse(DMA);
    expect_val(3'd1, 16'h0000, "R8 gated");
    wr(3'd3, 16'hFFFF);

    // R10 set beats clear
    pulse(DMA);
    wr_pulse(3'd1, 16'h1000, DMA);
    expect_val(3'd1, 16'h1000, "R10 set wins");

    // R11 interrupt line
    idle(2);
    expect_val(IRQ_ADDR, 16'h0000, "R11 sig off");
    wr(3'd5, 16'h1000);
    expect_val(IRQ_ADDR, 16'h0000, "R11 registered");
    idle(1);
    expect_val(IRQ_ADDR, 16'h0001, "R11 rise");
    wr(3'd1, 16'h1000);
    expect_val(IRQ_ADDR, 16'h0001, "R11 hold");
    idle(1);
    expect_val(IRQ_ADDR, 16'h0000, "R11 fall");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule